// File: doc/BRIEF.md
# Quadrature Local Oscillator and I/Q Mixer

This block moves a real intermediate-frequency sample stream toward baseband. A phase accumulator steps by a programmable frequency control word on every clock. The top bits of the phase address a constant quarter-wave table. That table yields a sine sample and a cosine sample a quarter cycle apart. Each accepted input sample is multiplied by the cosine to form the in-phase output and by the sine to form the quadrature output. Both products are rounded back to the input width. The I and Q lanes run in lockstep.

The oscillator runs freely, whether or not samples arrive, so its phase is a pure function of the clock count since reset and the control words applied. The control word for a tone at frequency f and sample rate fs is round(f · 2^PHASE_W / fs). For a 70 MHz IF at 250 MHz this gives 1202590843. A downstream low-pass stage, not part of this block, removes the sum-frequency image.

Top module: `nco_iq_mixer`

## Requirements
- R1: On every clock outside reset, the phase adds `fcw` modulo 2^PHASE_W. It wraps silently with no flag, and `fcw` = 0 freezes it.
- R2: A synchronous reset clears the phase to 0, drives `out_valid` to 0 and sets `out_i` and `out_q` to 0. The first sample captured after reset uses phase 0.
- R3: The oscillator samples are sin(θ) and cos(θ) scaled by 2^(LO_W-1)-1, within 1 LSB. Here θ = 2π(p+½)/2^ADDR_W, and p is the top ADDR_W bits of the phase.
- R4: The cosine lookup is the sine lookup advanced by one quadrant, that is, the top two index bits plus one. I uses the cosine and Q uses the sine.
- R5: `out_i` = round(x·cos_lo / 2^(LO_W-1)) and `out_q` = round(x·sin_lo / 2^(LO_W-1)), with halves rounded upward and the result saturated to DATA_W bits. Each output is within 2 LSB of x·A·cos θ / 2^(LO_W-1) (sin θ for Q), where A = 2^(LO_W-1)-1, including for an input of −2^(DATA_W-1).
- R6: `out_valid` equals `in_valid` two clock edges earlier. A sample is paired with the phase held just before the edge that captures it.
- R7: While `in_valid` is low, `in_sample` is ignored, and `out_i` and `out_q` hold their last values.
- R8: With `fcw` = round(70e6·2^32/250e6) = 1202590843, mixing a 70 MHz IF tone gives I and Q that follow the model of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fcw | input | PHASE_W | Phase increment per clock |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | DATA_W | Signed real input sample |
| out_valid | output | 1 | Qualifies `out_i` and `out_q` |
| out_i | output | DATA_W | Signed in-phase product |
| out_q | output | DATA_W | Signed quadrature product |

## Verification
A constant full-scale input turns I and Q into a direct view of the cosine and sine tables. With a step of 2^32/64 this covers every quadrant and the mirrored table index. A quarter-cycle step with the most negative input probes the rounding and saturation edge. A negative step that wraps, and a zero step, separate modular phase arithmetic from a stuck or flagged accumulator. A 70 MHz tone and a gapped valid pattern show whether the sample-to-phase pairing, the two-cycle latency and the output hold are right. A reset in mid-stream confirms that the phase restarts at zero.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

    // pi/2 in Q2.30
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // amp * sin(pi/2 * (idx + 0.5) / 2^qbits), rounded, via an odd Taylor series in Q30
    function automatic longint quarter_sine(input int idx, input int qbits, input longint amp);
        longint x;
        longint x2;
        longint term;
        longint acc;
        x    = (HALF_PI_Q30 * longint'(2 * idx + 1)) >>> (qbits + 1);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 6; k++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
            acc  = acc + term;
        end
        return (acc * amp + (64'sd1 <<< 29)) >>> 30;
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] fcw,
    output logic [PHASE_W-1:0] phase
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d       = acc_q;
        acc_d.phase = acc_q.phase + fcw;   // modulo 2^PHASE_W by width
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign phase = acc_q.phase;
endmodule

// File: rtl/nco_lo_lookup.sv
module nco_lo_lookup #(
    parameter int ADDR_W = 10,
    parameter int LO_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       idx,
    output logic signed [LO_W-1:0]  cos_lo,
    output logic signed [LO_W-1:0]  sin_lo
);
    localparam int     QBITS = ADDR_W - 2;
    localparam int     QN    = 1 << QBITS;
    localparam longint AMP   = (64'sd1 <<< (LO_W - 1)) - 64'sd1;

    // constant quarter-wave table, half-step offset so the mirror is exact
    logic signed [LO_W-1:0] rom [QN];
    for (genvar g = 0; g < QN; g++) begin : g_rom
        assign rom[g] = LO_W'(nco_mix_pkg::quarter_sine(g, QBITS, AMP));
    end

    // channel 0 = sine, channel 1 = sine one quadrant ahead = cosine
    logic signed [LO_W-1:0] lo_c [2];
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [1:0]             quad;
        logic [QBITS-1:0]       fine;
        logic signed [LO_W-1:0] mag;
        assign quad      = idx[ADDR_W-1 -: 2] + 2'(ch);
        assign fine      = quad[0] ? ~idx[QBITS-1:0] : idx[QBITS-1:0];
        assign mag       = rom[fine];
        assign lo_c[ch]  = quad[1] ? -mag : mag;
    end

    typedef struct packed {
        logic signed [LO_W-1:0] cos_v;
        logic signed [LO_W-1:0] sin_v;
    } lo_t;

    lo_t lo_d, lo_q;

    always_comb begin
        lo_d = lo_q;
        if (load) begin
            lo_d.cos_v = lo_c[1];
            lo_d.sin_v = lo_c[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lo_q <= '0;
        else     lo_q <= lo_d;
    end

    assign cos_lo = lo_q.cos_v;
    assign sin_lo = lo_q.sin_v;
endmodule

// File: rtl/nco_mix_lane.sv
module nco_mix_lane #(
    parameter int DATA_W = 16,
    parameter int LO_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic signed [DATA_W-1:0] sample,
    input  logic signed [LO_W-1:0]   lo,
    output logic signed [DATA_W-1:0] prod
);
    localparam int FULL_W = DATA_W + LO_W;
    localparam int SHIFT  = LO_W - 1;

    logic signed [FULL_W-1:0]     full_p;
    logic signed [FULL_W-1:0]     rnd_p;
    logic signed [FULL_W-1:0]     scaled;
    logic [FULL_W-DATA_W:0]       upper;
    logic                         fits;
    logic signed [DATA_W-1:0]     clipped;

    assign full_p = sample * lo;
    assign rnd_p  = full_p + $signed(FULL_W'(1) << (SHIFT - 1));
    assign scaled = rnd_p >>> SHIFT;
    assign upper  = scaled[FULL_W-1:DATA_W-1];
    assign fits   = (&upper) || (~|upper);

    always_comb begin
        if (fits)                clipped = scaled[DATA_W-1:0];
        else if (scaled[FULL_W-1]) clipped = {1'b1, {(DATA_W-1){1'b0}}};
        else                     clipped = {1'b0, {(DATA_W-1){1'b1}}};
    end

    typedef struct packed {
        logic signed [DATA_W-1:0] prod;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (load) ln_d.prod = clipped;
    end

    always_ff @(posedge clk) begin
        if (rst) ln_q <= '0;
        else     ln_q <= ln_d;
    end

    assign prod = ln_q.prod;
endmodule

// File: rtl/nco_iq_mixer.sv
module nco_iq_mixer #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    parameter int LO_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PHASE_W-1:0]       fcw,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);
    localparam int LANES = 2;

    logic [PHASE_W-1:0]     phase;
    logic signed [LO_W-1:0] lo_cos;
    logic signed [LO_W-1:0] lo_sin;

    typedef struct packed {
        logic                     v1;
        logic                     v2;
        logic signed [DATA_W-1:0] sample;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.v1 = in_valid;
        pipe_d.v2 = pipe_q.v1;
        if (in_valid) pipe_d.sample = in_sample;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .fcw   (fcw),
        .phase (phase)
    );

    nco_lo_lookup #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_lut (
        .clk    (clk),
        .rst    (rst),
        .load   (in_valid),
        .idx    (phase[PHASE_W-1 -: ADDR_W]),
        .cos_lo (lo_cos),
        .sin_lo (lo_sin)
    );

    logic signed [LO_W-1:0]   lane_lo  [LANES];
    logic signed [DATA_W-1:0] lane_out [LANES];
    assign lane_lo[0] = lo_cos;
    assign lane_lo[1] = lo_sin;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        nco_mix_lane #(.DATA_W(DATA_W), .LO_W(LO_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .load   (pipe_q.v1),
            .sample (pipe_q.sample),
            .lo     (lane_lo[ln]),
            .prod   (lane_out[ln])
        );
    end

    assign out_i     = lane_out[0];
    assign out_q     = lane_out[1];
    assign out_valid = pipe_q.v2;
endmodule

// File: rtl/nco_iq_mixer_chk.sv
module nco_iq_mixer_chk #(
    parameter int PHASE_W = 32,
    parameter int DATA_W  = 16,
    parameter int LO_W    = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [PHASE_W-1:0]       fcw,
    input logic [PHASE_W-1:0]       phase,
    input logic signed [LO_W-1:0]   lo_cos,
    input logic signed [LO_W-1:0]   lo_sin,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_i,
    input logic signed [DATA_W-1:0] out_q
);
    localparam logic signed [LO_W-1:0] AMP = {1'b0, {(LO_W-1){1'b1}}};

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1) |-> (phase == $past(phase) + $past(fcw)));

    assert_reset_clears_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase == '0 && !out_valid));

    assert_lo_range_R3: assert property (@(posedge clk) disable iff (rst)
        (lo_cos <= AMP && lo_cos >= -AMP && lo_sin <= AMP && lo_sin >= -AMP));

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !out_valid) |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind nco_iq_mixer nco_iq_mixer_chk #(
    .PHASE_W (PHASE_W),
    .DATA_W  (DATA_W),
    .LO_W    (LO_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fcw       (fcw),
    .phase     (phase),
    .lo_cos    (lo_cos),
    .lo_sin    (lo_sin),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/tb_nco_iq_mixer.sv
module tb_nco_iq_mixer;
    localparam real TWO_PI = 6.283185307179586;
    localparam real AMPL   = 32767.0;
    localparam real TOL    = 2.0;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        fcw = '0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench-side model state
    logic [31:0]        mph = '0;
    bit                 e1v = 1'b0, e2v = 1'b0;
    real                e1i = 0.0, e1q = 0.0, e2i = 0.0, e2q = 0.0;
    string              e1t = "", e2t = "";
    logic signed [15:0] last_i = '0, last_q = '0;

    always #4 clk = ~clk;

    nco_iq_mixer dut (
        .clk       (clk),
        .rst       (rst),
        .fcw       (fcw),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    function automatic real absr(input real r);
        return (r < 0.0) ? -r : r;
    endfunction

    function automatic real lo_model(input logic [31:0] ph, input bit sine);
        real a;
        a = TWO_PI * (real'(ph[31:22]) + 0.5) / 1024.0;
        return AMPL * (sine ? $sin(a) : $cos(a));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // called right after a falling edge
    task automatic check_out();
        if (e2v) begin
            chk(out_valid == 1'b1, "R6", "out_valid", longint'(out_valid), 1);
            chk(absr(real'(out_i) - e2i) <= TOL, e2t, "out_i", longint'(out_i), longint'(e2i));
            chk(absr(real'(out_q) - e2q) <= TOL, e2t, "out_q", longint'(out_q), longint'(e2q));
            last_i = out_i;
            last_q = out_q;
        end else begin
            chk(out_valid == 1'b0, "R6", "out_valid", longint'(out_valid), 0);
            chk(out_i == last_i && out_q == last_q, "R7", "held out_i",
                longint'(out_i), longint'(last_i));
        end
    endtask

    task automatic step(input bit v, input int x, input string rq);
        check_out();
        in_valid  = v;
        in_sample = 16'(x);
        e2v = e1v; e2i = e1i; e2q = e1q; e2t = e1t;
        e1v = v;
        e1i = real'(x) * lo_model(mph, 1'b0) / 32768.0;
        e1q = real'(x) * lo_model(mph, 1'b1) / 32768.0;
        e1t = rq;
        @(posedge clk);
        mph = mph + fcw;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mph = '0;
        e1v = 1'b0; e2v = 1'b0;
        last_i = '0; last_q = '0;
        chk(out_valid == 1'b0, "R2", "out_valid after reset", longint'(out_valid), 0);
        chk(out_i == 0 && out_q == 0, "R2", "out_i after reset", longint'(out_i), 0);
    endtask

    task automatic flush();
        step(1'b0, 0, "R7");
        step(1'b0, 0, "R7");
        step(1'b0, 0, "R7");
    endtask

    // R3 / R4: full-scale DC input exposes cosine on I and sine on Q
    task automatic t_dc_table();
        fcw = 32'd67108864;  // 2^32/64
        for (int n = 0; n < 70; n++) step(1'b1, 32767, "R3");
        fcw = 32'd16777216 + 32'd4194304;
        for (int n = 0; n < 40; n++) step(1'b1, 30000, "R4");
        flush();
    endtask

    // R5: quarter-cycle steps with the most negative input
    task automatic t_neg_full();
        do_reset();
        fcw = 32'h4000_0000;
        for (int n = 0; n < 12; n++) step(1'b1, -32768, "R5");
        flush();
    endtask

    // R1: wrapping negative step, then a frozen phase
    task automatic t_wrap_zero();
        fcw = 32'hF000_0001;
        for (int n = 0; n < 40; n++) step(1'b1, -20000, "R1");
        fcw = 32'h0;
        for (int n = 0; n < 10; n++) step(1'b1, 25000, "R1");
        flush();
    endtask

    // R8: 70 MHz IF tone at 250 MHz
    task automatic t_if70();
        real fs;
        real fi;
        fs  = 250.0e6;
        fi  = 70.0e6;
        fcw = 32'(longint'(fi * 4294967296.0 / fs + 0.5));
        chk(fcw == 32'd1202590843, "R8", "tuning word", longint'(fcw), 1202590843);
        for (int n = 0; n < 60; n++)
            step(1'b1, int'(20000.0 * $cos(TWO_PI * 0.28 * real'(n))), "R8");
        flush();
    endtask

    // R6 / R7: gapped valid pattern
    task automatic t_gaps();
        fcw = 32'd107374182;
        for (int n = 0; n < 30; n++) step((n % 3) != 1, 1000 * n - 15000, "R6");
        flush();
    endtask

    // R2: reset mid-stream restarts the phase at zero
    task automatic t_reset_mid();
        fcw = 32'd123456789;
        for (int n = 0; n < 5; n++) step(1'b1, 12000, "R2");
        do_reset();
        for (int n = 0; n < 8; n++) step(1'b1, 32767, "R2");
        flush();
    endtask

    initial begin
        do_reset();
        t_dc_table();
        t_neg_full();
        t_wrap_zero();
        t_if70();
        t_gaps();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule